// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block owns the housekeeping side of an asynchronous DRAM. When reset is released it holds both strobes inactive for a long settling pause. It then runs a fixed number of row-strobe-only warm-up cycles and raises `init_done`. After that, a free-running interval timer adds one owed refresh for each period. Each owed refresh is paid by one strobe sequence. The default period is 1562 cycles at 100 MHz, which keeps 1024 refreshes inside a 16 ms retention window.

Refreshes are negotiated with the access controller. The sequencer raises `ref_req` and waits for `ref_gnt`, then drives the strobes while `ref_own` is high. By default it uses the column-first ordering: the column strobe falls first, then the row strobe falls while the column strobe stays low. In this ordering the device picks the row itself, so no address is presented and the data bus is left alone. A build-time option switches to row-strobe-only refresh. In that mode the column strobe stays high and `row_addr` supplies a wrapping internal row count. Owed refreshes may pile up while the controller is busy. Once more than `POSTPONE_MAX` are outstanding, `ref_urgent` tells the controller to stop starting new accesses.

The state machine has eight states:
- `ST_PAUSE` holds the strobes high.
- `ST_WARM_LO` and `ST_WARM_HI` form the row-low and precharge halves of each warm-up cycle.
- `ST_IDLE` waits for an owed refresh.
- `ST_WAIT` raises the request.
- `ST_LEAD` is the column-first setup.
- `ST_ACT` holds the row strobe active.
- `ST_PRE` is the closing precharge.

The transitions are:
- pause expiry: `ST_PAUSE`→`ST_WARM_LO`
- row-low expiry: `ST_WARM_LO`→`ST_WARM_HI`
- precharge expiry: `ST_WARM_HI`→`ST_WARM_LO`, or →`ST_IDLE` after the last warm-up cycle
- debt present: `ST_IDLE`→`ST_WAIT`
- grant: `ST_WAIT`→`ST_LEAD`, or →`ST_ACT` in row-only mode
- setup expiry: `ST_LEAD`→`ST_ACT`
- active expiry: `ST_ACT`→`ST_PRE`
- precharge expiry: `ST_PRE`→`ST_IDLE`

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted: `ras_n` and `cas_n` are 1, `ref_req`, `ref_urgent` and `init_done` are 0, `ref_own` is 1 and `row_addr` is 0.
- R2: After reset release both strobes stay high for exactly `PAUSE_CYC` clock edges; `ras_n` is first seen low after edge number `PAUSE_CYC`.
- R3: After the pause, exactly `INIT_CYC` row-strobe pulses occur with `cas_n` held high. Each pulse is `T_RAS` cycles low and is followed by `T_RP` cycles high. `init_done` rises on edge `PAUSE_CYC + INIT_CYC*(T_RAS+T_RP)` and then stays high until reset.
- R4: `ref_req` is only ever high after `init_done`. The first request appears on edge `REF_INTERVAL+1` after `init_done` rises, and one refresh is owed every `REF_INTERVAL` cycles.
- R5: In column-first mode, a grant seen while requesting produces the following, sampled one cycle after each edge:
  - `T_CSR` cycles of `cas_n`=0 with `ras_n`=1;
  - then `T_RAS` cycles with both low;
  - then `T_RP` cycles with both high and `ref_own` still 1;
  - then `ref_own` drops to 0.
  `ref_req` drops as soon as the sequence starts.
- R6: A strobe is driven low only while `ref_own` is 1.
- R7: `ref_gnt` has no effect unless `ref_req` is high: the strobes stay high and `ref_own` stays 0.
- R8: Owed refreshes accumulate while no grant is given, and `ref_urgent` is 1 exactly when more than `POSTPONE_MAX` are owed. Under a held grant they are paid back to back, one full sequence each, until `ref_urgent` and `ref_req` both return to 0.
- R9: With `RAS_ONLY`=1, `cas_n` never goes low, and `row_addr` at each refresh row-strobe fall runs 0,1,2,… and wraps at 2^`ROW_W`.
- R10: With `RAS_ONLY`=0, `row_addr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller hands over the DRAM strobes |
| ref_req | output | 1 | Sequencer wants the strobes for a refresh |
| ref_urgent | output | 1 | Owed refreshes exceed the postponement limit; block new accesses |
| ref_own | output | 1 | Sequencer is driving the strobes (reset, power-up, or a granted refresh) |
| init_done | output | 1 | Power-up pause and warm-up cycles complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row to strobe in row-only refresh mode, 0 otherwise |

## Verification
The assertions assume that the access controller asserts `ref_gnt` only to hand over the strobes, and that it releases them only when `ref_own` falls. Every strobe relation the checker proves is therefore about the sequencer's own drive, not the merged bus. The bench follows this: it grants only when a request is visible or deliberately while idle, and it holds the grant through the whole sequence. The timing parameters are shrunk so that the pause, warm-up and several refresh periods all fit in a short run. No timing value is zero or one cycle, so every state actually dwells.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_WARM_LO,
        ST_WARM_HI,
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_ACT,
        ST_PRE
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_interval.sv
// Free-running period timer; one-cycle tick at the end of each period.
module dref_interval #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (!en)                    cnt <= '0;
        else if (cnt == W'(PERIOD - 1))  cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == W'(PERIOD - 1));
endmodule

// File: rtl/dref_backlog.sv
// Count of owed refreshes, saturating; urgent beyond the postponement limit.
module dref_backlog #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic sub,
    output logic pending,
    output logic urgent
);
    localparam int CAP = LIMIT + 2;
    localparam int W   = $clog2(CAP + 1);

    logic [W-1:0] owed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({add, sub})
                2'b10:   if (owed != W'(CAP)) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)      owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);
    assign urgent  = (owed > W'(LIMIT));
endmodule

// File: rtl/dref_rowcnt.sv
// Row pointer for row-only refresh; tied to zero in column-first mode.
module dref_rowcnt #(
    parameter int ROW_W  = 10,
    parameter int ENABLE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_q;

    generate
        if (ENABLE != 0) begin : g_count
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    row_q <= '0;
                else if (step) row_q <= row_q + 1'b1;
            end
        end else begin : g_zero
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    row_q <= '0;
                else if (step) row_q <= '0;
            end
        end
    endgenerate

    assign row = row_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CYC     = 8,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 4,
    parameter int T_CSR        = 2,
    parameter int REF_INTERVAL = 1562,
    parameter int POSTPONE_MAX = 8,
    parameter int ROW_W        = 10,
    parameter int RAS_ONLY     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             ref_own,
    output logic             init_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr
);
    localparam int LONGEST = max2(max2(PAUSE_CYC, T_RAS), max2(T_RP, T_CSR));
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int WARM_W  = $clog2(INIT_CYC + 1);

    seq_state_t        state, state_nx;
    logic [CNT_W-1:0]  tmr, tmr_nx;
    logic [WARM_W-1:0] warm, warm_nx;
    logic              tick, pending, hot, paid;

    assign paid = (state == ST_PRE) && (tmr == '0);

    dref_interval #(.PERIOD(REF_INTERVAL)) u_interval (
        .clk (clk), .rst_n (rst_n), .en (init_done), .tick (tick)
    );

    dref_backlog #(.LIMIT(POSTPONE_MAX)) u_backlog (
        .clk (clk), .rst_n (rst_n), .add (tick), .sub (paid),
        .pending (pending), .urgent (hot)
    );

    dref_rowcnt #(.ROW_W(ROW_W), .ENABLE(RAS_ONLY)) u_rowcnt (
        .clk (clk), .rst_n (rst_n), .step (paid), .row (row_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            tmr   <= CNT_W'(PAUSE_CYC - 1);
            warm  <= '0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
            warm  <= warm_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        tmr_nx   = (tmr != '0) ? tmr - 1'b1 : tmr;
        warm_nx  = warm;
        unique case (state)
            ST_PAUSE: if (tmr == '0) begin
                state_nx = ST_WARM_LO;
                tmr_nx   = CNT_W'(T_RAS - 1);
            end
            ST_WARM_LO: if (tmr == '0) begin
                state_nx = ST_WARM_HI;
                tmr_nx   = CNT_W'(T_RP - 1);
            end
            ST_WARM_HI: if (tmr == '0) begin
                if (warm == WARM_W'(INIT_CYC - 1)) begin
                    state_nx = ST_IDLE;
                end else begin
                    warm_nx  = warm + 1'b1;
                    state_nx = ST_WARM_LO;
                    tmr_nx   = CNT_W'(T_RAS - 1);
                end
            end
            ST_IDLE: if (pending) state_nx = ST_WAIT;
            ST_WAIT: if (ref_gnt) begin
                if (RAS_ONLY != 0) begin
                    state_nx = ST_ACT;
                    tmr_nx   = CNT_W'(T_RAS - 1);
                end else begin
                    state_nx = ST_LEAD;
                    tmr_nx   = CNT_W'(T_CSR - 1);
                end
            end
            ST_LEAD: if (tmr == '0) begin
                state_nx = ST_ACT;
                tmr_nx   = CNT_W'(T_RAS - 1);
            end
            ST_ACT: if (tmr == '0) begin
                state_nx = ST_PRE;
                tmr_nx   = CNT_W'(T_RP - 1);
            end
            ST_PRE: if (tmr == '0) state_nx = ST_IDLE;
            default: state_nx = ST_PAUSE;
        endcase
    end

    // outputs
    always_comb begin
        ras_n      = 1'b1;
        cas_n      = 1'b1;
        ref_req    = 1'b0;
        ref_own    = 1'b0;
        init_done  = 1'b0;
        unique case (state)
            ST_PAUSE, ST_WARM_HI: ref_own = 1'b1;
            ST_WARM_LO: begin
                ref_own = 1'b1;
                ras_n   = 1'b0;
            end
            ST_IDLE: init_done = 1'b1;
            ST_WAIT: begin
                init_done = 1'b1;
                ref_req   = 1'b1;
            end
            ST_LEAD: begin
                init_done = 1'b1;
                ref_own   = 1'b1;
                cas_n     = 1'b0;
            end
            ST_ACT: begin
                init_done = 1'b1;
                ref_own   = 1'b1;
                ras_n     = 1'b0;
                cas_n     = (RAS_ONLY != 0);
            end
            ST_PRE: begin
                init_done = 1'b1;
                ref_own   = 1'b1;
            end
            default: ref_own = 1'b1;
        endcase
        ref_urgent = hot && init_done;
    end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
    parameter int PAUSE_CYC = 20000,
    parameter int T_RAS     = 6,
    parameter int RAS_ONLY  = 0
) (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_urgent,
    input logic ref_own,
    input logic init_done,
    input logic ras_n,
    input logic cas_n
);
    int since_rst;
    int lo_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 0;
            lo_len    <= 0;
        end else begin
            if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
            lo_len <= ras_n ? 0 : lo_len + 1;
        end
    end

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PAUSE_CYC) |-> (ras_n && cas_n));

    p_ras_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_len == T_RAS));

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_req_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> init_done);

    p_col_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && init_done && (RAS_ONLY == 0)) |-> (!cas_n && $past(!cas_n)));

    p_own_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> ref_own);

    p_start_needs_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_own) |-> ($past(ref_req) && $past(ref_gnt)));

    p_urgent_after_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> init_done);

    p_row_only_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && (RAS_ONLY != 0)) |-> cas_n);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .PAUSE_CYC (PAUSE_CYC),
    .T_RAS     (T_RAS),
    .RAS_ONLY  (RAS_ONLY)
) u_chk (.*);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
    localparam int P_PAUSE = 50;
    localparam int P_INIT  = 8;
    localparam int P_RAS   = 4;
    localparam int P_RP    = 3;
    localparam int P_CSR   = 2;
    localparam int P_INT   = 100;
    localparam int P_POST  = 2;
    localparam int P_ROW   = 3;
    localparam int INIT_EDGE = P_PAUSE + P_INIT * (P_RAS + P_RP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0, gnt_ro = 1'b0;
    logic req, urg, own, done, ras_n, cas_n;
    logic req_ro, urg_ro, own_ro, done_ro, ras_ro, cas_ro;
    logic [P_ROW-1:0] row, row_ro;

    int total = 0, bad = 0, cyc = 0, own_err = 0;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(P_PAUSE), .INIT_CYC(P_INIT), .T_RAS(P_RAS), .T_RP(P_RP),
        .T_CSR(P_CSR), .REF_INTERVAL(P_INT), .POSTPONE_MAX(P_POST),
        .ROW_W(P_ROW), .RAS_ONLY(0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req),
        .ref_urgent(urg), .ref_own(own), .init_done(done),
        .ras_n(ras_n), .cas_n(cas_n), .row_addr(row)
    );

    dram_refresh_seq #(
        .PAUSE_CYC(P_PAUSE), .INIT_CYC(P_INIT), .T_RAS(P_RAS), .T_RP(P_RP),
        .T_CSR(P_CSR), .REF_INTERVAL(P_INT), .POSTPONE_MAX(P_POST),
        .ROW_W(P_ROW), .RAS_ONLY(1)
    ) uut_ro (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_ro), .ref_req(req_ro),
        .ref_urgent(urg_ro), .ref_own(own_ro), .init_done(done_ro),
        .ras_n(ras_ro), .cas_n(cas_ro), .row_addr(row_ro)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // R6 monitor on both instances
    always @(negedge clk) begin
        if (rst_n && (!ras_n || !cas_n) && !own)       own_err <= own_err + 1;
        if (rst_n && (!ras_ro || !cas_ro) && !own_ro)  own_err <= own_err + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        gnt = 1'b0;
        gnt_ro = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_init();
        while (!done) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ras_n", ras_n, 1);
        chk("R1 cas_n", cas_n, 1);
        chk("R1 req", req, 0);
        chk("R1 urgent", urg, 0);
        chk("R1 init_done", done, 0);
        chk("R1 own", own, 1);
        chk("R1 row_addr", row, 0);
    endtask

    task automatic t_powerup();
        int first_lo = -1, falls = 0, lo = 0, hi = 0, wbad = 0, gbad = 0;
        int cas_lo = 0, req_early = 0, done_at = -1;
        logic prev = 1'b1;
        do_reset();
        while (cyc < 1000 && !done) begin
            @(negedge clk);
            if (done) begin
                done_at = cyc;
                if (hi != P_RP) gbad++;
            end else begin
                if (!cas_n) cas_lo++;
                if (req) req_early++;
                if (!ras_n) begin
                    if (first_lo < 0) first_lo = cyc;
                    if (prev) begin
                        falls++;
                        if (falls > 1 && hi != P_RP) gbad++;
                        lo = 0;
                    end
                    lo++;
                end else begin
                    if (!prev) begin
                        if (lo != P_RAS) wbad++;
                        hi = 0;
                    end
                    hi++;
                end
                prev = ras_n;
            end
        end
        chk("R2 first ras low edge", first_lo, P_PAUSE);
        chk("R3 warm-up pulse count", falls, P_INIT);
        chk("R3 pulse width errors", wbad, 0);
        chk("R3 precharge gap errors", gbad, 0);
        chk("R3 cas low during warm-up", cas_lo, 0);
        chk("R4 request before init", req_early, 0);
        chk("R3 init_done edge", done_at, INIT_EDGE);
        repeat (5) @(negedge clk);
        chk("R3 init_done held", done, 1);
    endtask

    task automatic t_first_refresh();
        int seen = -1;
        int ex_own[10] = '{1,1,1,1,1,1,1,1,1,0};
        int ex_cas[10] = '{0,0,0,0,0,0,1,1,1,1};
        int ex_ras[10] = '{1,1,0,0,0,0,1,1,1,1};
        int mism = 0, req_mid = 0;
        while (!req && cyc < INIT_EDGE + 3 * P_INT) @(negedge clk);
        seen = cyc;
        chk("R4 first request edge", seen, INIT_EDGE + P_INT + 1);
        gnt = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (own != ex_own[k][0] || cas_n != ex_cas[k][0] || ras_n != ex_ras[k][0])
                mism++;
            if (req) req_mid++;
        end
        chk("R5 column-first strobe sequence mismatches", mism, 0);
        chk("R5 request held during sequence", req_mid, 0);
        gnt = 1'b0;
    endtask

    task automatic t_ignore_grant();
        int lows = 0, owns = 0;
        gnt = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!ras_n || !cas_n) lows++;
            if (own) owns++;
        end
        gnt = 1'b0;
        chk("R7 strobe lows on idle grant", lows, 0);
        chk("R7 own on idle grant", owns, 0);
        chk("R10 row_addr in column-first mode", row, 0);
    endtask

    task automatic t_backlog();
        int falls = 0;
        logic prev = 1'b1;
        do_reset();
        wait_init();
        while (cyc < INIT_EDGE + 250) @(negedge clk);
        chk("R8 urgent with two owed", urg, 0);
        chk("R8 request while owed", req, 1);
        while (cyc < INIT_EDGE + 320) @(negedge clk);
        chk("R8 urgent with three owed", urg, 1);
        gnt = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (prev && !ras_n) falls++;
            prev = ras_n;
        end
        gnt = 1'b0;
        chk("R8 back-to-back refresh count", falls, 3);
        chk("R8 urgent cleared", urg, 0);
        chk("R8 request cleared", req, 0);
    endtask

    task automatic t_row_only();
        int falls = 0, cas_lo = 0, wrong = 0;
        logic prev = 1'b1;
        do_reset();
        while (!done_ro) @(negedge clk);
        gnt_ro = 1'b1;
        while (falls < 9 && cyc < INIT_EDGE + 12 * P_INT) begin
            @(negedge clk);
            if (!cas_ro) cas_lo++;
            if (row != '0) wrong++;
            if (prev && !ras_ro) begin
                chk("R9 row at refresh", int'(row_ro), falls % (1 << P_ROW));
                falls++;
            end
            prev = ras_ro;
        end
        gnt_ro = 1'b0;
        chk("R9 refreshes seen", falls, 9);
        chk("R9 cas low in row-only mode", cas_lo, 0);
        chk("R10 row_addr nonzero in column-first mode", wrong, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_first_refresh();
        t_ignore_grant();
        t_backlog();
        t_row_only();
        chk("R6 strobe low without own", own_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule